// File: doc/BRIEF.md
# Chien Search and Forney Error Corrector

This block takes the error-locator and error-evaluator polynomials of a Reed-Solomon block over GF(2^8) and finds the error positions and their magnitudes. A set of evaluation cells steps through the field elements, one codeword position for each accepted input symbol. The same cells supply three sums. The full locator sum is checked for zero to flag a root. Its odd-power part serves as the derivative term in the magnitude formula. A second cell set evaluates x times the evaluator polynomial. The magnitude is the evaluator value times the inverse of the odd-power sum, taken from a computed inversion table, and it is forced to zero wherever no root was found.

While the search runs, each received symbol and its magnitude are written into a local store. After the last symbol of the block, the block decides whether the block can be corrected. It then streams the stored symbols out, one per cycle. Each symbol is XORed with its magnitude, or is left as received if the block was judged uncorrectable. Shortened codes are handled by starting the search at the position of the first symbol actually sent.

Top module: `rs_chien_forney`

## Requirements
- R1: After reset, `out_valid_o`, `with_err_o` and `uncorr_o` are low.
- R2: For a block with σ(x)=1 and Ω(x)=0, every output symbol equals the received symbol and `with_err_o` stays low.
- R3: For up to `t_i` errors whose locators lie inside the block, each output symbol equals the received symbol XOR the error magnitude Y = Ω(X⁻¹)/σ'(X⁻¹) (first generator root α¹, field polynomial x⁸+x⁴+x³+x²+1, α=0x02). This also holds with `t_i` errors.
- R4: At positions where σ has no root, `err_val_o` is zero and `with_err_o` is low. `with_err_o` is only high together with `out_valid_o`.
- R5: The symbols of a block arrive highest position first: the first symbol is position `len_i`−1 and the last is position 0. Any `len_i` from 1 to 255 is searched only over those positions.
- R6: If deg σ exceeds `t_i`, then `uncorr_o` is high for the whole output block, the symbols come out exactly as received, and `err_val_o` is zero.
- R7: If the number of roots found within the block differs from deg σ, the block is treated as in R6.
- R8: The `len_i` output symbols come on consecutive cycles. The first one is valid in the second cycle after the clock edge that accepted the last input symbol.
- R9: Cycles with `sym_valid_i` low do not advance the search, so gaps in the input stream do not change the results.
- R10: Coefficient j of σ sits in `sigma_i[8j+7:8j]` for j=0..T_MAX, and coefficient i of Ω sits in `omega_i[8i+7:8i]`. Both are captured when `load_i` is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture polynomials, length and t (accepted while idle) |
| sigma_i | input | 8*(T_MAX+1) | Error-locator coefficients σ0..σT |
| omega_i | input | 8*T_MAX | Error-evaluator coefficients Ω0..ΩT-1 |
| len_i | input | 8 | Block length n, 1..255 |
| t_i | input | $clog2(T_MAX+1) | Correction capability of this block |
| sym_valid_i | input | 1 | Received symbol present |
| sym_i | input | 8 | Received symbol, highest position first |
| data_o | output | 8 | Corrected (or raw) symbol |
| err_val_o | output | 8 | Magnitude applied to this symbol |
| with_err_o | output | 1 | This symbol was altered |
| uncorr_o | output | 1 | Current output block is uncorrectable |
| out_valid_o | output | 1 | Output symbol present |

## Verification
The assertions watch every cycle for the following. The altered-symbol flag never appears without valid output. An uncorrectable block never carries a nonzero magnitude. The drain phase never skips a cycle. The root count never runs ahead of the number of positions searched. The evaluation cells hold their value across input gaps. The actual arithmetic can only be shown by the bench scenarios: correct magnitudes at the right positions, the start offset for shortened blocks, and the two uncorrectable verdicts (degree above t, and roots falling outside the block). The bench builds σ and Ω from its own chosen error patterns and compares the output symbols against the received data XOR those errors.

// File: rtl/rs_chien_pkg.sv
package rs_chien_pkg;
  localparam int SW = 8;
  localparam logic [SW:0] FIELD_POLY = 9'h11D;

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_DRAIN} cf_state_e;

  function automatic logic [SW-1:0] gf_mul(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] acc;
    logic [SW-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SW; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SW-1] ? ((sh << 1) ^ FIELD_POLY[SW-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [SW-1:0] gf_pow(input logic [SW-1:0] base, input logic [7:0] e);
    logic [SW-1:0] r;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (e[i]) r = gf_mul(r, base);
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_eval_cell.sv
module rs_eval_cell
  import rs_chien_pkg::*;
#(
  parameter int J = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [SW-1:0] coef_i,
  input  logic [SW-1:0] start_i,
  output logic [SW-1:0] val_o
);
  localparam logic [7:0]    JE      = 8'(J);
  localparam logic [SW-1:0] ALPHA_J = gf_pow(8'h02, JE);

  logic [SW-1:0] val_q;
  logic [SW-1:0] seed;

  // coefficient pre-rotated to the first position actually sent
  assign seed = gf_mul(coef_i, gf_pow(start_i, JE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= seed;
    else if (step_i) val_q <= gf_mul(val_q, ALPHA_J);
  end

  assign val_o = val_q;

  p_cell_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(val_q));
endmodule

// File: rtl/rs_inv_rom.sv
module rs_inv_rom
  import rs_chien_pkg::*;
(
  input  logic [SW-1:0] addr_i,
  output logic [SW-1:0] inv_o
);
  function automatic logic [256*SW-1:0] build_tbl();
    logic [256*SW-1:0] tbl;
    tbl = '0;
    for (int x = 1; x < 256; x++) tbl[x*SW +: SW] = gf_pow(8'(x), 8'd254);
    return tbl;
  endfunction

  localparam logic [256*SW-1:0] INV_TBL = build_tbl();

  assign inv_o = INV_TBL[addr_i*SW +: SW];
endmodule

// File: rtl/rs_sym_store.sv
module rs_sym_store #(
  parameter int W     = 16,
  parameter int DEPTH = 255,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/rs_chien_forney.sv
module rs_chien_forney
  import rs_chien_pkg::*;
#(
  parameter int T_MAX = 8,
  parameter int N_MAX = 255,
  localparam int TW   = $clog2(T_MAX + 1),
  localparam int LW   = 8,
  localparam int AW   = $clog2(N_MAX)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [SW*(T_MAX+1)-1:0] sigma_i,
  input  logic [SW*T_MAX-1:0]     omega_i,
  input  logic [LW-1:0]           len_i,
  input  logic [TW-1:0]           t_i,
  input  logic                    sym_valid_i,
  input  logic [SW-1:0]           sym_i,
  output logic [SW-1:0]           data_o,
  output logic [SW-1:0]           err_val_o,
  output logic                    with_err_o,
  output logic                    uncorr_o,
  output logic                    out_valid_o
);
  cf_state_e     state_q;
  logic [LW-1:0] n_q, idx_q, roots_q;
  logic [TW-1:0] t_q, deg_q, deg_c;
  logic          uncorr_q;

  logic          cell_load, cell_step;
  logic [SW-1:0] start_base;
  logic [SW-1:0] sig_val [T_MAX+1];
  logic [SW-1:0] om_val  [T_MAX+1];
  logic [SW-1:0] sig_sum, odd_sum, om_sum, inv_odd, err_c;
  logic          zero_c;
  logic [2*SW-1:0] rd_word;
  logic [LW-1:0] roots_nx;

  assign cell_load = load_i && (state_q == ST_IDLE);
  assign cell_step = sym_valid_i && (state_q == ST_SEARCH);

  // first sent symbol sits at position n-1: start at alpha^-(n-1) = alpha^(256-n)
  assign start_base = gf_pow(8'h02, ~len_i + 8'd1);

  for (genvar j = 0; j <= T_MAX; j++) begin : g_sig
    rs_eval_cell #(.J(j)) i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cell_load),
      .step_i (cell_step),
      .coef_i (sigma_i[j*SW +: SW]),
      .start_i(start_base),
      .val_o  (sig_val[j])
    );
  end

  // x*Omega(x): coefficient of x^j is Omega_(j-1)
  assign om_val[0] = '0;
  for (genvar j = 1; j <= T_MAX; j++) begin : g_om
    rs_eval_cell #(.J(j)) i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cell_load),
      .step_i (cell_step),
      .coef_i (omega_i[(j-1)*SW +: SW]),
      .start_i(start_base),
      .val_o  (om_val[j])
    );
  end

  always_comb begin
    sig_sum = '0;
    odd_sum = '0;
    om_sum  = '0;
    for (int j = 0; j <= T_MAX; j++) begin
      sig_sum = sig_sum ^ sig_val[j];
      om_sum  = om_sum ^ om_val[j];
      if (j % 2 == 1) odd_sum = odd_sum ^ sig_val[j];
    end
  end

  rs_inv_rom i_inv (
    .addr_i(odd_sum),
    .inv_o (inv_odd)
  );

  assign zero_c = (sig_sum == '0);
  assign err_c  = zero_c ? gf_mul(om_sum, inv_odd) : '0;

  always_comb begin
    deg_c = '0;
    for (int j = 1; j <= T_MAX; j++)
      if (sigma_i[j*SW +: SW] != '0) deg_c = TW'(j);
  end

  rs_sym_store #(.W(2*SW), .DEPTH(N_MAX)) i_store (
    .clk_i    (clk_i),
    .wr_en_i  (cell_step),
    .wr_addr_i(idx_q[AW-1:0]),
    .wr_data_i({sym_i, err_c}),
    .rd_addr_i(idx_q[AW-1:0]),
    .rd_data_o(rd_word)
  );

  assign roots_nx = roots_q + LW'(zero_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      n_q         <= '0;
      idx_q       <= '0;
      roots_q     <= '0;
      t_q         <= '0;
      deg_q       <= '0;
      uncorr_q    <= 1'b0;
      data_o      <= '0;
      err_val_o   <= '0;
      with_err_o  <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      with_err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            state_q  <= ST_SEARCH;
            n_q      <= len_i;
            t_q      <= t_i;
            deg_q    <= deg_c;
            idx_q    <= '0;
            roots_q  <= '0;
            uncorr_q <= 1'b0;
          end
        end
        ST_SEARCH: begin
          if (sym_valid_i) begin
            roots_q <= roots_nx;
            if (idx_q == n_q - 1'b1) begin
              state_q  <= ST_DRAIN;
              idx_q    <= '0;
              uncorr_q <= (roots_nx != LW'(deg_q)) || (deg_q > t_q);
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          out_valid_o <= 1'b1;
          data_o      <= rd_word[2*SW-1:SW] ^ (uncorr_q ? '0 : rd_word[SW-1:0]);
          err_val_o   <= uncorr_q ? '0 : rd_word[SW-1:0];
          with_err_o  <= !uncorr_q && (rd_word[SW-1:0] != '0);
          if (idx_q == n_q - 1'b1) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign uncorr_o = uncorr_q;

  p_werr_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    with_err_o |-> out_valid_o);
  p_uncorr_raw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && uncorr_o) |-> (err_val_o == '0 && !with_err_o));
  p_drain_stream_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |=> out_valid_o);
  p_roots_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |-> (roots_q <= idx_q));
endmodule

// File: tb/test_rs_chien_forney.sv
module test_rs_chien_forney;
  localparam int T_MAX = 8;
  localparam int TW = $clog2(T_MAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [8*(T_MAX+1)-1:0] sigma = '0;
  logic [8*T_MAX-1:0] omega = '0;
  logic [7:0] len = 8'd0;
  logic [TW-1:0] t = '0;
  logic sym_valid = 1'b0;
  logic [7:0] sym = 8'd0;
  logic [7:0] data, err_val;
  logic with_err, uncorr, out_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int       epos [T_MAX+2];
  logic [7:0] emag [T_MAX+2];
  int       ne;
  logic [7:0] rx [256];

  always #5 clk = ~clk;

  rs_chien_forney #(.T_MAX(T_MAX)) i_rs_chien_forney (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .sigma_i(sigma), .omega_i(omega),
    .len_i(len), .t_i(t), .sym_valid_i(sym_valid), .sym_i(sym),
    .data_o(data), .err_val_o(err_val), .with_err_o(with_err),
    .uncorr_o(uncorr), .out_valid_o(out_valid));

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11D << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] alpha_pow(input int e);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < e; i++) r = fmul(r, 8'h02);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Build sigma = prod(1 + X x), Omega = sum Y X prod_{j!=i}(1 + Xj x)
  task automatic build_polys();
    logic [7:0] sg [T_MAX+2];
    logic [7:0] om [T_MAX+2];
    for (int j = 0; j < T_MAX + 2; j++) begin sg[j] = 8'h00; om[j] = 8'h00; end
    sg[0] = 8'h01;
    for (int i = 0; i < ne; i++) begin
      logic [7:0] x = alpha_pow(epos[i]);
      for (int j = T_MAX + 1; j >= 1; j--) sg[j] = sg[j] ^ fmul(x, sg[j-1]);
    end
    for (int i = 0; i < ne; i++) begin
      logic [7:0] pr [T_MAX+2];
      for (int j = 0; j < T_MAX + 2; j++) pr[j] = 8'h00;
      pr[0] = fmul(emag[i], alpha_pow(epos[i]));
      for (int k = 0; k < ne; k++) if (k != i) begin
        logic [7:0] x = alpha_pow(epos[k]);
        for (int j = T_MAX + 1; j >= 1; j--) pr[j] = pr[j] ^ fmul(x, pr[j-1]);
      end
      for (int j = 0; j < T_MAX + 2; j++) om[j] = om[j] ^ pr[j];
    end
    for (int j = 0; j <= T_MAX; j++) sigma[8*j +: 8] = sg[j];
    for (int j = 0; j < T_MAX; j++) omega[8*j +: 8] = om[j];
  endtask

  task automatic run_block(input string req, input int n, input int tt, input bit gaps,
                           input bit exp_unc, input int seed);
    build_polys();
    for (int k = 0; k < n; k++) rx[k] = 8'((k * 37 + seed * 11 + 5) & 255);
    @(negedge clk);
    load = 1'b1; len = 8'(n); t = TW'(tt);
    @(negedge clk);
    load = 1'b0;
    sigma = '1; omega = '1; // must be ignored after capture (R10)
    for (int k = 0; k < n; k++) begin
      if (gaps && (k % 3 == 1)) begin
        sym_valid = 1'b0; sym = 8'hA5;
        @(negedge clk);
      end
      sym_valid = 1'b1; sym = rx[k];
      @(negedge clk);
    end
    sym_valid = 1'b0;
    // R8: first output one edge after the drain starts
    check(out_valid == 1'b0, "R8 first-out timing (before)", out_valid, 0);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int p = n - 1 - k;
      logic [7:0] y = 8'h00;
      if (!exp_unc) for (int i = 0; i < ne; i++) if (epos[i] == p) y = emag[i];
      check(out_valid == 1'b1, {req, " R8 contiguous output"}, out_valid, 1);
      if (k == 0) check(uncorr == exp_unc, {req, " R6/R7 verdict"}, uncorr, exp_unc);
      check(data == (rx[k] ^ y), {req, " R3/R5 data"}, data, rx[k] ^ y);
      check(with_err == (y != 8'h00), {req, " R4 with_err"}, with_err, y != 0);
      if (y == 8'h00) check(err_val == 8'h00, {req, " R4 err_val zero"}, err_val, 0);
      @(negedge clk);
    end
    check(out_valid == 1'b0, {req, " R8 block end"}, out_valid, 0);
  endtask

  task automatic test_reset();
    check(out_valid == 1'b0 && with_err == 1'b0 && uncorr == 1'b0, "R1 reset",
          {out_valid, with_err, uncorr}, 0);
  endtask

  task automatic test_clean();
    ne = 0;
    run_block("R2 clean", 255, 8, 1'b0, 1'b0, 1);
  endtask

  task automatic test_single();
    ne = 1; epos[0] = 10; emag[0] = 8'h5C;
    run_block("R3 single", 255, 8, 1'b0, 1'b0, 2);
  endtask

  task automatic test_full_t();
    ne = 8;
    epos[0] = 254; epos[1] = 200; epos[2] = 150; epos[3] = 100;
    epos[4] = 77;  epos[5] = 50;  epos[6] = 3;   epos[7] = 0;
    for (int i = 0; i < 8; i++) emag[i] = 8'(i * 29 + 1);
    run_block("R3 t-errors", 255, 8, 1'b0, 1'b0, 3);
  endtask

  task automatic test_short();
    ne = 3; epos[0] = 203; epos[1] = 0; epos[2] = 100;
    emag[0] = 8'hFF; emag[1] = 8'h01; emag[2] = 8'h80;
    run_block("R5 shortened", 204, 8, 1'b0, 1'b0, 4);
  endtask

  task automatic test_gaps();
    ne = 4; epos[0] = 60; epos[1] = 59; epos[2] = 1; epos[3] = 33;
    emag[0] = 8'h12; emag[1] = 8'h34; emag[2] = 8'h56; emag[3] = 8'h78;
    run_block("R9 gaps", 64, 4, 1'b1, 1'b0, 5);
  endtask

  task automatic test_deg_over_t();
    ne = 3; epos[0] = 20; epos[1] = 40; epos[2] = 7;
    emag[0] = 8'h11; emag[1] = 8'h22; emag[2] = 8'h33;
    run_block("R6 deg>t", 48, 2, 1'b0, 1'b1, 6);
  endtask

  task automatic test_root_mismatch();
    ne = 1; epos[0] = 230; emag[0] = 8'h44;
    run_block("R7 root outside block", 204, 8, 1'b0, 1'b1, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_clean();
    test_single();
    test_full_t();
    test_short();
    test_gaps();
    test_deg_over_t();
    test_root_mismatch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule